// File: doc/BRIEF.md
# Dual-Class Coherence Message Queue

This block carries coherence traffic in one direction between a private cache and the directory. Two classes of message travel through it. A request holds a core identifier, a line address and a 2-bit target coherence state. A response holds the same three fields, plus a cache-line payload and a flag that says whether the payload is valid. Each class has its own enqueue port with a valid/ready handshake and its own internal FIFO. The depth of each FIFO is set by a parameter.

The consumer sees a single head port. That port exposes one message at a time, together with a class tag, and a one-cycle `deq` strobe removes the message. If any response is waiting, the head port shows the oldest response. The oldest request appears only when no response is stored. A stalled request therefore can never hold back a response, and this keeps the coherence protocol free of deadlock.

Separate status outputs report whether any request is stored and whether any response is stored. The block does not interpret the state codes; it only stores and forwards them.

Top module: `cohMsgQueue`

## Requirements
- R1: After reset, `hasReq`, `hasResp` and `headValid` are 0, and both `reqReady` and `rspReady` are 1.
- R2: `hasReq` is 1 exactly when at least one request is stored, and `hasResp` is 1 exactly when at least one response is stored. `headValid` equals `hasReq` OR `hasResp`.
- R3: While any response is stored, the head port presents the oldest response. The oldest request is presented only when no response is stored.
- R4: Within each class, messages leave in the order they were accepted. The core, address, state, payload-valid flag and payload are returned unchanged.
- R5: `headIsResp` is 1 when the head message is a response and 0 when it is a request.
- R6: When a class FIFO is full and is not being popped in that cycle, that class's ready output is 0, and a push offered while ready is 0 is dropped. The fill level of one class never changes the ready output of the other class.
- R7: A `deq` while nothing is stored changes nothing. A push accepted in the same cycle as such a `deq` is kept.
- R8: When a class is full and its head message is popped in the same cycle, that class's ready output is 1 and the offered push is accepted.
- R9: Each class accepts exactly `DEPTH` messages before its ready output falls.
- R10: When the head message is a request, `headHasData` and `headData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request push offered |
| reqReady | output | 1 | Request FIFO can take a push this cycle |
| reqCore | input | CORE_W | Request core identifier |
| reqAddr | input | ADDR_W | Request line address |
| reqState | input | 2 | Request target state code |
| rspValid | input | 1 | Response push offered |
| rspReady | output | 1 | Response FIFO can take a push this cycle |
| rspCore | input | CORE_W | Response core identifier |
| rspAddr | input | ADDR_W | Response line address |
| rspState | input | 2 | Response state code |
| rspHasData | input | 1 | Response payload is valid |
| rspData | input | LINE_W | Response cache-line payload |
| headValid | output | 1 | A message is presented at the head port |
| headIsResp | output | 1 | Head message class: 1 = response, 0 = request |
| headCore | output | CORE_W | Head core identifier |
| headAddr | output | ADDR_W | Head line address |
| headState | output | 2 | Head state code |
| headHasData | output | 1 | Head payload is valid |
| headData | output | LINE_W | Head cache-line payload |
| deq | input | 1 | Remove the head message |
| hasReq | output | 1 | At least one request is stored |
| hasResp | output | 1 | At least one response is stored |

## Verification
The bench runs with `DEPTH` = 2, so full, one-entry and empty states come up often. It first drives directed sequences and then long pseudo-random runs, all checked against a reference queue for each class.

The directed sequences cover the following cases:
- Pushing into a full class: a design that ignored the full condition would overwrite the oldest entry, and a later head message would come out wrong.
- Pushing and popping a full class in the same cycle: a design that did not see the pop would stall, and ready would read 0.
- Popping an empty queue: a design that did not guard this would wrap its counters, and `hasReq` would rise with no message stored.
- A response arriving behind waiting requests: a design with the wrong priority would present the request first, and the tag and fields would not match.

// File: rtl/cohqPkg.sv
package cohqPkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic reqPush;
    logic reqPop;
    logic rspPush;
    logic rspPop;
    logic selRsp;
  } cohqStrobe_t;

  // Class index used by the per-class generate loop
  localparam int unsigned CLS_REQ = 0;
  localparam int unsigned CLS_RSP = 1;
  localparam int unsigned NUM_CLS = 2;

endpackage

// File: rtl/cohqFifoMem.sv
module cohqFifoMem #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];

endmodule

// File: rtl/cohqCtrl.sv
module cohqCtrl
  import cohqPkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspValid,
  input  logic        deq,
  output logic        reqReady,
  output logic        rspReady,
  output logic        hasReq,
  output logic        hasResp,
  output cohqStrobe_t strobe
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [NUM_CLS-1:0] want;
  logic [NUM_CLS-1:0] nonEmpty;
  logic [NUM_CLS-1:0] full;
  logic [NUM_CLS-1:0] pop;
  logic [NUM_CLS-1:0] ready;
  logic [NUM_CLS-1:0] push;

  assign want[CLS_REQ] = reqValid;
  assign want[CLS_RSP] = rspValid;

  // Responses always win the single head port
  always_comb begin
    pop[CLS_RSP] = deq && nonEmpty[CLS_RSP];
    pop[CLS_REQ] = deq && nonEmpty[CLS_REQ] && !nonEmpty[CLS_RSP];
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic [CW-1:0] cnt;

    assign nonEmpty[c] = (cnt != '0);
    assign full[c]     = (cnt == FULL_CNT);
    assign ready[c]    = !full[c] || pop[c];
    assign push[c]     = want[c] && ready[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
      end else begin
        case ({push[c], pop[c]})
          2'b10:   cnt <= cnt + CW'(1);
          2'b01:   cnt <= cnt - CW'(1);
          default: cnt <= cnt;
        endcase
      end
    end
  end

  assign reqReady = ready[CLS_REQ];
  assign rspReady = ready[CLS_RSP];
  assign hasReq   = nonEmpty[CLS_REQ];
  assign hasResp  = nonEmpty[CLS_RSP];

  always_comb begin
    strobe.reqPush = push[CLS_REQ];
    strobe.reqPop  = pop[CLS_REQ];
    strobe.rspPush = push[CLS_RSP];
    strobe.rspPop  = pop[CLS_RSP];
    strobe.selRsp  = nonEmpty[CLS_RSP];
  end

endmodule

// File: rtl/cohqData.sv
module cohqData
  import cohqPkg::*;
#(
  parameter int unsigned CORE_W = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 64,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cohqStrobe_t       strobe,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqState,
  input  logic [CORE_W-1:0] rspCore,
  input  logic [ADDR_W-1:0] rspAddr,
  input  logic [1:0]        rspState,
  input  logic              rspHasData,
  input  logic [LINE_W-1:0] rspData,
  output logic [CORE_W-1:0] headCore,
  output logic [ADDR_W-1:0] headAddr,
  output logic [1:0]        headState,
  output logic              headHasData,
  output logic [LINE_W-1:0] headData
);
  localparam int unsigned HDR_W = CORE_W + ADDR_W + 2;
  localparam int unsigned RSP_W = HDR_W + 1 + LINE_W;

  logic [HDR_W-1:0] reqIn;
  logic [HDR_W-1:0] reqOut;
  logic [RSP_W-1:0] rspIn;
  logic [RSP_W-1:0] rspOut;

  assign reqIn = {reqCore, reqAddr, reqState};
  assign rspIn = {rspCore, rspAddr, rspState, rspHasData, rspData};

  cohqFifoMem #(.WIDTH(HDR_W), .DEPTH(DEPTH)) u_reqMem (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobe.reqPush),
    .pop    (strobe.reqPop),
    .wrData (reqIn),
    .rdData (reqOut)
  );

  cohqFifoMem #(.WIDTH(RSP_W), .DEPTH(DEPTH)) u_rspMem (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobe.rspPush),
    .pop    (strobe.rspPop),
    .wrData (rspIn),
    .rdData (rspOut)
  );

  // Head selection: requests carry no payload
  always_comb begin
    if (strobe.selRsp) begin
      {headCore, headAddr, headState, headHasData, headData} = rspOut;
    end else begin
      {headCore, headAddr, headState} = reqOut;
      headHasData = 1'b0;
      headData    = '0;
    end
  end

endmodule

// File: rtl/cohMsgQueue.sv
module cohMsgQueue
  import cohqPkg::*;
#(
  parameter int unsigned CORE_W = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 64,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqState,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [CORE_W-1:0] rspCore,
  input  logic [ADDR_W-1:0] rspAddr,
  input  logic [1:0]        rspState,
  input  logic              rspHasData,
  input  logic [LINE_W-1:0] rspData,
  output logic              headValid,
  output logic              headIsResp,
  output logic [CORE_W-1:0] headCore,
  output logic [ADDR_W-1:0] headAddr,
  output logic [1:0]        headState,
  output logic              headHasData,
  output logic [LINE_W-1:0] headData,
  input  logic              deq,
  output logic              hasReq,
  output logic              hasResp
);
  cohqStrobe_t strobe;

  cohqCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspValid (rspValid),
    .deq      (deq),
    .reqReady (reqReady),
    .rspReady (rspReady),
    .hasReq   (hasReq),
    .hasResp  (hasResp),
    .strobe   (strobe)
  );

  cohqData #(
    .CORE_W (CORE_W),
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .DEPTH  (DEPTH)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqCore     (reqCore),
    .reqAddr     (reqAddr),
    .reqState    (reqState),
    .rspCore     (rspCore),
    .rspAddr     (rspAddr),
    .rspState    (rspState),
    .rspHasData  (rspHasData),
    .rspData     (rspData),
    .headCore    (headCore),
    .headAddr    (headAddr),
    .headState   (headState),
    .headHasData (headHasData),
    .headData    (headData)
  );

  assign headValid  = hasReq || hasResp;
  assign headIsResp = strobe.selRsp;

endmodule

// File: rtl/cohqChk.sv
module cohqChk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic rspValid,
  input logic reqReady,
  input logic rspReady,
  input logic headValid,
  input logic headIsResp,
  input logic headHasData,
  input logic deq,
  input logic hasReq,
  input logic hasResp
);

  // R3
  resp_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    hasResp |-> (headValid && headIsResp));

  // R10
  req_no_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && !headIsResp) |-> !headHasData);

  // R7
  empty_deq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!headValid && deq && !reqValid && !rspValid) |=> !headValid);

  // R6
  req_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> hasReq);

  // R6
  rsp_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspReady |-> hasResp);

  // R8
  req_full_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hasReq && !hasResp && deq) |-> reqReady);

  // R2
  head_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    headValid == (hasReq || hasResp));

endmodule

bind cohMsgQueue cohqChk u_cohqChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .rspValid    (rspValid),
  .reqReady    (reqReady),
  .rspReady    (rspReady),
  .headValid   (headValid),
  .headIsResp  (headIsResp),
  .headHasData (headHasData),
  .deq         (deq),
  .hasReq      (hasReq),
  .hasResp     (hasResp)
);

// File: tb/cohMsgQueue_bench.sv
module cohMsgQueue_bench;
  localparam int unsigned CW = 2;
  localparam int unsigned AW = 8;
  localparam int unsigned LW = 16;
  localparam int unsigned D  = 2;
  localparam int unsigned HW = CW + AW + 2;
  localparam int unsigned PW = HW + 1 + LW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, rspValid = 1'b0, deq = 1'b0, rspHasData = 1'b0;
  logic [CW-1:0] reqCore = '0, rspCore = '0;
  logic [AW-1:0] reqAddr = '0, rspAddr = '0;
  logic [1:0] reqState = '0, rspState = '0;
  logic [LW-1:0] rspData = '0;
  logic reqReady, rspReady, headValid, headIsResp, headHasData, hasReq, hasResp;
  logic [CW-1:0] headCore;
  logic [AW-1:0] headAddr;
  logic [1:0] headState;
  logic [LW-1:0] headData;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1bad_c0de;
  logic [HW-1:0] modelReq[$];
  logic [PW-1:0] modelRsp[$];

  always #2 clk = ~clk;

  cohMsgQueue #(.CORE_W(CW), .ADDR_W(AW), .LINE_W(LW), .DEPTH(D)) u_cohMsgQueue (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqCore(reqCore),
    .reqAddr(reqAddr), .reqState(reqState),
    .rspValid(rspValid), .rspReady(rspReady), .rspCore(rspCore),
    .rspAddr(rspAddr), .rspState(rspState), .rspHasData(rspHasData),
    .rspData(rspData),
    .headValid(headValid), .headIsResp(headIsResp), .headCore(headCore),
    .headAddr(headAddr), .headState(headState), .headHasData(headHasData),
    .headData(headData), .deq(deq), .hasReq(hasReq), .hasResp(hasResp)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic pv, input logic dq);
    logic [31:0] r1, r2;
    bit expReqRdy, expRspRdy, popReq, popRsp;
    r1 = rnd();
    r2 = rnd();
    @(negedge clk);
    reqValid = rv; rspValid = pv; deq = dq;
    reqCore = r1[1:0]; reqAddr = r1[9:2]; reqState = r1[11:10];
    rspCore = r1[13:12]; rspAddr = r1[21:14]; rspState = r1[23:22];
    rspHasData = r1[24]; rspData = r2[15:0];
    #1;
    // R2: status flags follow the stored counts
    chk(hasReq == (modelReq.size() != 0), "R2", 64'(hasReq), 64'(modelReq.size() != 0));
    chk(hasResp == (modelRsp.size() != 0), "R2", 64'(hasResp), 64'(modelRsp.size() != 0));
    chk(headValid == (hasReq || hasResp), "R2", 64'(headValid), 64'(hasReq || hasResp));
    if (modelRsp.size() != 0) begin
      // R3 and R5: a waiting response owns the head
      chk(headIsResp == 1'b1, "R3", 64'(headIsResp), 64'd1);
      // R4: response order and fields
      chk({headCore, headAddr, headState, headHasData, headData} == modelRsp[0], "R4",
          64'({headCore, headAddr, headState, headHasData, headData}), 64'(modelRsp[0]));
    end else if (modelReq.size() != 0) begin
      chk(headIsResp == 1'b0, "R5", 64'(headIsResp), 64'd0);
      chk({headCore, headAddr, headState} == modelReq[0], "R4",
          64'({headCore, headAddr, headState}), 64'(modelReq[0]));
      chk(headHasData == 1'b0 && headData == '0, "R10",
          64'({headHasData, headData}), 64'd0);
    end
    popRsp = dq && (modelRsp.size() != 0);
    popReq = dq && (modelReq.size() != 0) && (modelRsp.size() == 0);
    expReqRdy = (modelReq.size() < D) || popReq;
    expRspRdy = (modelRsp.size() < D) || popRsp;
    if (modelReq.size() < D)
      chk(reqReady == expReqRdy, "R9", 64'(reqReady), 64'(expReqRdy));
    else if (popReq)
      chk(reqReady == expReqRdy, "R8", 64'(reqReady), 64'(expReqRdy));
    else
      chk(reqReady == expReqRdy, "R6", 64'(reqReady), 64'(expReqRdy));
    if (modelRsp.size() < D)
      chk(rspReady == expRspRdy, "R9", 64'(rspReady), 64'(expRspRdy));
    else if (popRsp)
      chk(rspReady == expRspRdy, "R8", 64'(rspReady), 64'(expRspRdy));
    else
      chk(rspReady == expRspRdy, "R6", 64'(rspReady), 64'(expRspRdy));
    if (popRsp) void'(modelRsp.pop_front());
    if (popReq) void'(modelReq.pop_front());
    if (rv && expReqRdy) modelReq.push_back({reqCore, reqAddr, reqState});
    if (pv && expRspRdy)
      modelRsp.push_back({rspCore, rspAddr, rspState, rspHasData, rspData});
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    chk(!hasReq && !hasResp && !headValid, "R1", 64'({hasReq, hasResp, headValid}), 64'd0);
    chk(reqReady && rspReady, "R1", 64'({reqReady, rspReady}), 64'd3);

    // R7: deq on empty queue
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    #1;
    chk(!headValid && !hasReq, "R7", 64'({headValid, hasReq}), 64'd0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);

    // R6/R9: overfill requests, then responses; requests stay untouched
    for (int i = 0; i < D + 2; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < D + 2; i++) step(1'b0, 1'b1, 1'b0);
    // R8: full class with simultaneous push and pop
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    // R3: drain everything, responses first
    for (int i = 0; i < 2 * D + 2; i++) step(1'b0, 1'b0, 1'b1);

    // Pseudo-random sweeps with different traffic mixes
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 2000; i++) begin
        logic [31:0] r;
        logic [3:0] pr, pp, pd;
        r = rnd();
        case (p)
          0: begin pr = 12; pp = 12; pd = 4;  end
          1: begin pr = 8;  pp = 8;  pd = 8;  end
          2: begin pr = 4;  pp = 4;  pd = 14; end
          3: begin pr = 12; pp = 1;  pd = 7;  end
          default: begin pr = 14; pp = 14; pd = 13; end
        endcase
        step(r[3:0] < pr, r[7:4] < pp, r[11:8] < pd);
      end
    end
    for (int i = 0; i < 2 * D + 2; i++) step(1'b0, 1'b0, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule